// File: doc/BRIEF.md
# Resolution-Programmable Angle Tracking Counter

This block holds the digital shaft angle of a tracking converter. A loop oscillator, which lies outside the block, delivers step requests, each with a direction. Every accepted step moves a 16-bit, MSB-aligned angle register by one least-significant unit of the currently selected resolution. It also produces a timed busy pulse, a direction flag and an active-low major-carry flag. The major-carry and direction flags let an external counter track whole turns.

The resolution is 10, 12, 14 or 16 bits and is chosen by two select pins. The block samples those pins only as the busy pulse ends, so a resolution change never lands inside an update. Bits below the selected resolution always read zero. When the resolution drops, the bits that fall out of use are cleared on the capture edge. A request that arrives while an update is in progress is held in a one-deep queue and served after the pulse.

Top module: `angle_track_counter`

## Requirements
- R1: The select code {res_b_i,res_a_i} maps 00 to 10 bits (step weight 64), 01 to 12 bits (weight 16), 10 to 14 bits (weight 4) and 11 to 16 bits (weight 1). Each step adds the weight when counting up, or subtracts it when counting down, modulo 2^16.
- R2: Angle bits below the selected resolution are always 0. Bit 15 is the MSB and weighs 180 degrees, and each lower bit halves that weight.
- R3: An accepted step raises busy_o for exactly BUSY_CYCLES clock cycles. The angle keeps its old value during the first busy cycle, changes once at the end of that cycle, and does not change outside updates and resolution captures.
- R4: The select pins are sampled only on the clock edge where busy_o falls. Pin changes at any other time have no effect on the angle or on the step weight.
- R5: dir_o is 1 for counting up and 0 for counting down. It takes the step's direction one cycle before busy_o rises and stays stable for the whole pulse.
- R6: A request made while an update is in progress is queued, together with its direction. busy_o stays low for two cycles after the current pulse, and then the queued step is served.
- R7: mcarry_no is 0 when dir_o is 1 and the angle equals the largest value of the selected resolution. It is also 0 when dir_o is 0 and the angle is zero. In all other cases it is 1.
- R8: When a lower resolution is captured, the newly unused low bits of the angle are cleared on that same edge.
- R9: After reset, the angle is 0, busy_o is 0, dir_o is 1, mcarry_no is 1 and the resolution is 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Step request, sampled on each rising edge |
| step_up_i | input | 1 | Direction of the request, 1 for up |
| res_a_i | input | 1 | Resolution select, low bit |
| res_b_i | input | 1 | Resolution select, high bit |
| angle_o | output | 16 | Angle, MSB aligned |
| busy_o | output | 1 | Update pulse |
| dir_o | output | 1 | Direction of the current or last update |
| mcarry_no | output | 1 | Major carry, active low |

## Verification
The assertions assume that BUSY_CYCLES is at least 2, so that the update strobe and the capture strobe never fall in the same cycle. They also assume that step requests are synchronous to the clock. The bench drives every input on the falling clock edge, so requests and pin changes are always stable at the sampling edge. The bench issues queued requests only after busy_o is high. Pin wiggles happen either while the block is idle or before a step, so each capture sees a value chosen by the bench.

// File: rtl/angle_trk_pkg.sv
package angle_trk_pkg;
  localparam int ANGLE_W    = 16;
  localparam int MIN_RES    = 10;
  localparam int RES_STRIDE = 2;

  typedef logic [1:0]         res_code_t;
  typedef logic [ANGLE_W-1:0] angle_t;
  typedef enum logic [1:0] {SQ_IDLE, SQ_SETUP, SQ_PULSE} seq_state_t;

  function automatic int res_bits(res_code_t c);
    return MIN_RES + RES_STRIDE * int'(c);
  endfunction

  function automatic int drop_bits(res_code_t c);
    return ANGLE_W - res_bits(c);
  endfunction

  // Ones over the bits in use, zeros below.
  function automatic angle_t res_mask(res_code_t c);
    angle_t ones;
    ones = '1;
    return ones << drop_bits(c);
  endfunction

  // Weight of one step at the given resolution.
  function automatic angle_t res_lsb(res_code_t c);
    angle_t one;
    one = angle_t'(1);
    return one << drop_bits(c);
  endfunction

  function automatic angle_t step_angle(angle_t a, logic up, res_code_t c);
    return up ? a + res_lsb(c) : a - res_lsb(c);
  endfunction

  function automatic logic carry_hit(angle_t a, logic up, res_code_t c);
    return up ? (a == res_mask(c)) : (a == '0);
  endfunction
endpackage

// File: rtl/step_sequencer.sv
module step_sequencer #(
  parameter int BUSY_CYCLES = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_req_i,
  input  logic step_up_i,
  output logic busy_o,
  output logic dir_o,
  output logic upd_o,
  output logic cap_o
);
  import angle_trk_pkg::*;

  localparam int CNT_W = (BUSY_CYCLES > 2) ? $clog2(BUSY_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BUSY_CYCLES - 1);

  seq_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;
  logic             pend_up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= SQ_IDLE;
      cnt_q     <= '0;
      pend_q    <= 1'b0;
      pend_up_q <= 1'b1;
      dir_o     <= 1'b1;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          if (pend_q) begin
            state_q <= SQ_SETUP;
            dir_o   <= pend_up_q;
            pend_q  <= step_req_i;
            if (step_req_i) pend_up_q <= step_up_i;
          end else if (step_req_i) begin
            state_q <= SQ_SETUP;
            dir_o   <= step_up_i;
          end
        end
        SQ_SETUP: begin
          state_q <= SQ_PULSE;
          cnt_q   <= '0;
          if (step_req_i) begin
            pend_q    <= 1'b1;
            pend_up_q <= step_up_i;
          end
        end
        default: begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == LAST) state_q <= SQ_IDLE;
          if (step_req_i) begin
            pend_q    <= 1'b1;
            pend_up_q <= step_up_i;
          end
        end
      endcase
    end
  end

  assign busy_o = (state_q == SQ_PULSE);
  assign upd_o  = busy_o && (cnt_q == '0);
  assign cap_o  = busy_o && (cnt_q == LAST);
endmodule

// File: rtl/angle_accum.sv
module angle_accum #(
  parameter logic [1:0] RESET_CODE = 2'b11
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        upd_i,
  input  logic                        cap_i,
  input  logic                        dir_i,
  input  angle_trk_pkg::res_code_t    pins_i,
  output angle_trk_pkg::angle_t       angle_o,
  output angle_trk_pkg::res_code_t    res_o,
  output logic                        mcarry_no
);
  import angle_trk_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      angle_o <= '0;
      res_o   <= RESET_CODE;
    end else begin
      if (upd_i) angle_o <= step_angle(angle_o, dir_i, res_o);
      if (cap_i) begin
        res_o   <= pins_i;
        angle_o <= angle_o & res_mask(pins_i);
      end
    end
  end

  assign mcarry_no = ~carry_hit(angle_o, dir_i, res_o);
endmodule

// File: rtl/angle_track_counter.sv
module angle_track_counter #(
  parameter int         BUSY_CYCLES = 50,
  parameter logic [1:0] RESET_CODE  = 2'b11
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        step_i,
  input  logic        step_up_i,
  input  logic        res_a_i,
  input  logic        res_b_i,
  output logic [15:0] angle_o,
  output logic        busy_o,
  output logic        dir_o,
  output logic        mcarry_no
);
  import angle_trk_pkg::*;

  logic      upd_w;
  logic      cap_w;
  res_code_t res_w;
  res_code_t pins_w;

  assign pins_w = {res_b_i, res_a_i};

  step_sequencer #(.BUSY_CYCLES(BUSY_CYCLES)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_req_i (step_i),
    .step_up_i  (step_up_i),
    .busy_o     (busy_o),
    .dir_o      (dir_o),
    .upd_o      (upd_w),
    .cap_o      (cap_w)
  );

  angle_accum #(.RESET_CODE(RESET_CODE)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (upd_w),
    .cap_i     (cap_w),
    .dir_i     (dir_o),
    .pins_i    (pins_w),
    .angle_o   (angle_o),
    .res_o     (res_w),
    .mcarry_no (mcarry_no)
  );
endmodule

// File: rtl/angle_track_checker.sv
module angle_track_checker #(
  parameter int BUSY_CYCLES = 50
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy,
  input logic        dir,
  input logic        upd,
  input logic        cap,
  input logic [15:0] angle,
  input logic [1:0]  res
);
  import angle_trk_pkg::*;

  logic [15:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   run_q <= '0;
    else if (busy) run_q <= run_q + 16'd1;
    else           run_q <= '0;
  end

  assert_upd_in_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |-> busy);
  assert_angle_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd && !cap) |=> $stable(angle));
  assert_busy_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && $past(busy)) |-> (run_q == 16'(BUSY_CYCLES)));
  assert_low_bits_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((angle & ~res_mask(res)) == 16'h0000));
  assert_res_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap |=> $stable(res));
  assert_dir_steady_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> $stable(dir));
  assert_gap_after_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |=> !busy);
endmodule

bind angle_track_counter angle_track_checker #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .busy   (busy_o),
  .dir    (dir_o),
  .upd    (upd_w),
  .cap    (cap_w),
  .angle  (angle_o),
  .res    (res_w)
);

// File: tb/test_angle_track_counter.sv
module test_angle_track_counter;
  localparam int BUSY = 50;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_i = 1'b0;
  logic        step_up_i = 1'b1;
  logic        res_a_i = 1'b1;
  logic        res_b_i = 1'b1;
  logic [15:0] angle_o;
  logic        busy_o, dir_o, mcarry_no;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  logic [15:0] m_angle = 16'h0000;
  logic [1:0]  m_res   = 2'b11;

  always #5 clk = ~clk;

  angle_track_counter #(.BUSY_CYCLES(BUSY)) i_angle_track_counter (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step_i), .step_up_i(step_up_i),
    .res_a_i(res_a_i), .res_b_i(res_b_i), .angle_o(angle_o),
    .busy_o(busy_o), .dir_o(dir_o), .mcarry_no(mcarry_no)
  );

  // {up, b, a} per step
  localparam logic [2:0] VEC [19] = '{
    3'b111, 3'b100, 3'b000, 3'b100, 3'b101, 3'b101, 3'b010, 3'b010,
    3'b011, 3'b011, 3'b100, 3'b000, 3'b000, 3'b100, 3'b100, 3'b000,
    3'b100, 3'b100, 3'b000
  };

  function automatic logic [15:0] b_mask(logic [1:0] c);
    case (c)
      2'b00:   return 16'hFFC0;
      2'b01:   return 16'hFFF0;
      2'b10:   return 16'hFFFC;
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic logic [15:0] b_weight(logic [1:0] c);
    return (~b_mask(c)) + 16'd1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_step(input logic up, input logic [1:0] pins);
    int w;
    logic exp_mc;
    @(negedge clk);
    step_up_i = up; {res_b_i, res_a_i} = pins; step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0;
    check(dir_o == up, "R5 dir before pulse", dir_o, up);
    check(busy_o == 1'b0, "R5 busy low in setup", busy_o, 0);
    @(negedge clk);
    check(busy_o == 1'b1, "R3 busy rise", busy_o, 1);
    check(angle_o == m_angle, "R3 angle held first cycle", angle_o, m_angle);
    m_angle = up ? m_angle + b_weight(m_res) : m_angle - b_weight(m_res);
    @(negedge clk);
    check(angle_o == m_angle, "R1 step weight", angle_o, m_angle);
    w = 2;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (!busy_o) break;
      w++;
    end
    check(w == BUSY, "R3 busy width", w, BUSY);
    m_res = pins;
    m_angle = m_angle & b_mask(m_res);
    check(angle_o == m_angle, "R8 capture mask", angle_o, m_angle);
    check((angle_o & ~b_mask(m_res)) == 16'h0, "R2 low bits zero", angle_o, m_angle);
    exp_mc = !((up && m_angle == b_mask(m_res)) || (!up && m_angle == 16'h0));
    check(mcarry_no == exp_mc, "R7 major carry", mcarry_no, exp_mc);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int low;
    logic [15:0] hold;
    repeat (3) @(negedge clk);
    check(angle_o == 16'h0, "R9 reset angle", angle_o, 0);
    check(busy_o == 1'b0, "R9 reset busy", busy_o, 0);
    check(dir_o == 1'b1, "R9 reset dir", dir_o, 1);
    check(mcarry_no == 1'b1, "R9 reset carry", mcarry_no, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // first vector checks the 16-bit reset resolution (R9, R1)
    for (int i = 0; i < 19; i++) run_step(VEC[i][2], VEC[i][1:0]);

    // R4: idle pin changes leave angle and weight untouched
    hold = angle_o;
    @(negedge clk);
    {res_b_i, res_a_i} = ~m_res;
    repeat (30) @(negedge clk);
    check(angle_o == hold, "R4 idle pins ignored", angle_o, hold);
    run_step(1'b1, m_res);
    run_step(1'b0, 2'b11);
    run_step(1'b1, 2'b11);

    // R6: queued request during pulse
    hold = m_angle;
    @(negedge clk);
    step_up_i = 1'b1; step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0;
    repeat (5) @(negedge clk);
    step_up_i = 1'b0; step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0;
    for (int k = 0; k < 1000; k++) begin
      if (!busy_o) break;
      @(negedge clk);
    end
    check(angle_o == hold + 16'd1, "R6 first step", angle_o, hold + 16'd1);
    low = 1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (busy_o) break;
      low++;
    end
    check(low == 2, "R6 gap before queued pulse", low, 2);
    check(dir_o == 1'b0, "R6 queued direction", dir_o, 0);
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (!busy_o) break;
    end
    check(angle_o == hold, "R6 queued step served", angle_o, hold);
    repeat (4) @(negedge clk);
    check(busy_o == 1'b0, "R6 no extra pulse", busy_o, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule